// File: doc/BRIEF.md
# Scanline Sprite Texture Renderer

This block composes the sprite layer of one video line at a time. A table of 64 sprite entries, written byte by byte from the CPU side, describes each sprite's screen position, size, mirroring and the point in a 256x256 texture page where its image begins. When a line-start pulse arrives with a line number, the block first zeroes its 256-pixel line buffer. It then walks the table from entry 0 upward, picks every enabled entry whose vertical span covers that line, fetches the matching row of 8-bit texels from texture memory, and writes every non-zero texel into the buffer at its wrapped screen column.

Texture memory sits outside the block and answers each request after a fixed number of cycles. A 16-bit page register places the texture page anywhere in a 24-bit byte space. Once the whole table has been walked and the last texel has landed, a done flag goes high, and the pixel stage can read the finished line by column index.

Top module: `spr_line_renderer`

## Requirements
- R1: The table holds 64 entries of 8 bytes at CPU byte address entry*8 + offset. Offset 0 holds the attributes, offset 1 the Y position, offset 2 the X position, offset 4 the texture X start and offset 5 the texture Y start. Writes to offsets 3, 6 and 7 have no effect on the rendered line.
- R2: An entry whose attribute bit 7 is 0 draws nothing.
- R3: Attribute bit 0 makes a sprite 16 pixels wide instead of 8. Attribute bit 1 makes it 16 lines tall instead of 8. A sprite covers line L when (L - Y) mod 256 is less than its height.
- R4: Attribute bit 2 mirrors the sprite left to right, so texel column c lands at screen X + width-1-c. Attribute bit 3 mirrors it top to bottom, so line offset d uses texture row height-1-d.
- R5: The texel for row r and column c is read at byte address base*256 + ((texY + r) mod 256)*256 + ((texX + c) mod 256), taken modulo 2^24. Within one sprite, columns are requested in increasing order.
- R6: A texel value of 0 is transparent and leaves the buffer pixel unchanged.
- R7: Screen columns wrap modulo 256. Sprite rows also wrap past line 255 into line 0.
- R8: Entries are drawn in increasing index order, so where two sprites overlap, the non-zero texel of the higher-indexed entry is the one left in the buffer.
- R9: A line-start pulse clears the done flag in the next cycle and resets all 256 buffer pixels to 0 before any sprite is drawn. Done rises once all 64 entries are processed and all fetched texels are written, and no texture request is made while done is high.
- R10: Texture read data is taken exactly TEX_LAT cycles after the cycle in which the request was made. A line-buffer read returns the pixel of the address presented in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | Table byte write strobe |
| cpu_addr | input | 9 | Table byte address (entry*8 + offset) |
| cpu_wdata | input | 8 | Table write data |
| tex_base | input | 16 | Texture page base, in units of 256 bytes |
| line_start | input | 1 | Starts rendering of a new line |
| line_num | input | 8 | Line to render, sampled with line_start |
| tex_req | output | 1 | Texture read request |
| tex_addr | output | 24 | Texture byte address |
| tex_rdata | input | 8 | Texture data, valid TEX_LAT cycles after tex_req |
| lb_raddr | input | 8 | Line-buffer read column |
| lb_rdata | output | 8 | Line-buffer pixel, one cycle after lb_raddr |
| done | output | 1 | Line complete |

## Verification
The bench builds the block with its default table of 64 eight-byte entries and a 256-pixel buffer, but sets the texture latency to 3 instead of 2. Several texel fetches are then in flight when a sprite ends, when the next entry is scanned, and when the scan finishes, so the drain before done and the ordering of overlapping writes come into play. The texture model returns a value computed from the address and gives 0 wherever the low nibble of the address is 0. Every sprite that is wide enough or that wraps in texture space therefore shows transparent holes at known columns, and the bench compares all 256 pixels of each line against its own model.

// File: rtl/spr_render_pkg.sv
package spr_render_pkg;

  localparam int COORD_W  = 8;
  localparam int NUM_FLDS = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_FETCH,
    ST_EVAL,
    ST_DRAW,
    ST_DRAIN,
    ST_DONE
  } seq_state_t;

  typedef struct packed {
    logic               en;
    logic               vflip;
    logic               hflip;
    logic               tall;
    logic               wide;
    logic [COORD_W-1:0] ypos;
    logic [COORD_W-1:0] xpos;
    logic [COORD_W-1:0] tex_x;
    logic [COORD_W-1:0] tex_y;
  } spr_entry_t;

  // byte offset inside an entry of each stored field
  function automatic logic [2:0] field_ofs(input int f);
    case (f)
      0:       return 3'd0;
      1:       return 3'd1;
      2:       return 3'd2;
      3:       return 3'd4;
      default: return 3'd5;
    endcase
  endfunction

endpackage

// File: rtl/spr_attr_ram.sv
module spr_attr_ram
  import spr_render_pkg::*;
#(
  parameter int ENTRIES     = 64,
  parameter int ENTRY_BYTES = 8,
  localparam int IDX_W      = $clog2(ENTRIES),
  localparam int BYTE_W     = $clog2(ENTRY_BYTES),
  localparam int ADDR_W     = IDX_W + BYTE_W
) (
  input  logic             clk,
  input  logic             we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] ridx,
  output spr_entry_t       rentry
);

  logic [BYTE_W-1:0] wofs;
  logic [IDX_W-1:0]  widx;
  assign wofs = waddr[BYTE_W-1:0];
  assign widx = waddr[ADDR_W-1:BYTE_W];

  // one narrow memory per stored field; unstored offsets are dropped
  for (genvar f = 0; f < NUM_FLDS; f++) begin : g_fld
    if (f == 0) begin : g_attr
      logic [4:0] mem [ENTRIES];
      logic [4:0] q;
      always_ff @(posedge clk) begin
        if (we && wofs == BYTE_W'(field_ofs(f)))
          mem[widx] <= {wdata[7], wdata[3:0]};
        q <= mem[ridx];
      end
    end else begin : g_byte
      logic [7:0] mem [ENTRIES];
      logic [7:0] q;
      always_ff @(posedge clk) begin
        if (we && wofs == BYTE_W'(field_ofs(f)))
          mem[widx] <= wdata;
        q <= mem[ridx];
      end
    end
  end

  assign rentry.en    = g_fld[0].g_attr.q[4];
  assign rentry.vflip = g_fld[0].g_attr.q[3];
  assign rentry.hflip = g_fld[0].g_attr.q[2];
  assign rentry.tall  = g_fld[0].g_attr.q[1];
  assign rentry.wide  = g_fld[0].g_attr.q[0];
  assign rentry.ypos  = g_fld[1].g_byte.q;
  assign rentry.xpos  = g_fld[2].g_byte.q;
  assign rentry.tex_x = g_fld[3].g_byte.q;
  assign rentry.tex_y = g_fld[4].g_byte.q;

endmodule

// File: rtl/spr_line_buf.sv
module spr_line_buf #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/spr_line_seq.sv
module spr_line_seq
  import spr_render_pkg::*;
#(
  parameter int ENTRIES  = 64,
  parameter int BASE_W   = 16,
  parameter int TEX_LAT  = 2,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int TEX_AW  = BASE_W + COORD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               line_start,
  input  logic [COORD_W-1:0] line_num,
  input  logic [BASE_W-1:0]  tex_base,
  output logic [IDX_W-1:0]   ridx,
  input  spr_entry_t         rentry,
  output logic               tex_req,
  output logic [TEX_AW-1:0]  tex_addr,
  input  logic [7:0]         tex_rdata,
  output logic               lb_we,
  output logic [COORD_W-1:0] lb_waddr,
  output logic [7:0]         lb_wdata,
  output logic               done
);

  seq_state_t         st;
  logic [IDX_W-1:0]   idx;
  logic [COORD_W-1:0] clr_cnt;
  logic [COORD_W-1:0] line_q;
  logic [COORD_W-1:0] sx, tx0, tyr;
  logic               hflip_q;
  logic [3:0]         col, col_last;

  logic               pv  [TEX_LAT];
  logic [COORD_W-1:0] ppx [TEX_LAT];

  // entry evaluation
  logic [COORD_W-1:0] dy;
  logic [4:0]         hgt;
  logic               hit;
  logic [3:0]         row_sel;
  logic               last_idx;

  assign dy       = line_q - rentry.ypos;
  assign hgt      = rentry.tall ? 5'd16 : 5'd8;
  assign hit      = rentry.en && (dy < COORD_W'(hgt));
  assign row_sel  = rentry.vflip ? ((rentry.tall ? 4'd15 : 4'd7) - dy[3:0]) : dy[3:0];
  assign last_idx = (idx == IDX_W'(ENTRIES - 1));

  // draw datapath
  logic [3:0]         col_off;
  logic [COORD_W-1:0] cur_px;
  assign col_off  = hflip_q ? (col_last - col) : col;
  assign cur_px   = sx + COORD_W'(col_off);

  assign ridx     = idx;
  assign tex_req  = (st == ST_DRAW);
  assign tex_addr = {tex_base + BASE_W'(tyr), tx0 + COORD_W'(col)};

  logic pend;
  always_comb begin
    pend = 1'b0;
    for (int k = 0; k < TEX_LAT; k++) pend = pend | pv[k];
  end

  always_comb begin
    if (st == ST_CLEAR) begin
      lb_we    = 1'b1;
      lb_waddr = clr_cnt;
      lb_wdata = 8'd0;
    end else begin
      lb_we    = pv[TEX_LAT-1] && (tex_rdata != 8'd0);
      lb_waddr = ppx[TEX_LAT-1];
      lb_wdata = tex_rdata;
    end
  end

  // fetch pipeline: screen column travels alongside each request
  always_ff @(posedge clk) begin
    if (rst || line_start) begin
      for (int k = 0; k < TEX_LAT; k++) pv[k] <= 1'b0;
    end else begin
      pv[0] <= tex_req;
      for (int k = 1; k < TEX_LAT; k++) pv[k] <= pv[k-1];
    end
    ppx[0] <= cur_px;
    for (int k = 1; k < TEX_LAT; k++) ppx[k] <= ppx[k-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      idx      <= '0;
      clr_cnt  <= '0;
      line_q   <= '0;
      done     <= 1'b0;
      sx       <= '0;
      tx0      <= '0;
      tyr      <= '0;
      hflip_q  <= 1'b0;
      col      <= '0;
      col_last <= '0;
    end else if (line_start) begin
      st      <= ST_CLEAR;
      idx     <= '0;
      clr_cnt <= '0;
      line_q  <= line_num;
      done    <= 1'b0;
    end else begin
      case (st)
        ST_CLEAR: begin
          clr_cnt <= clr_cnt + 1'b1;
          if (clr_cnt == '1) st <= ST_FETCH;
        end
        ST_FETCH: st <= ST_EVAL;
        ST_EVAL: begin
          if (hit) begin
            sx       <= rentry.xpos;
            tx0      <= rentry.tex_x;
            tyr      <= rentry.tex_y + COORD_W'(row_sel);
            hflip_q  <= rentry.hflip;
            col_last <= rentry.wide ? 4'd15 : 4'd7;
            col      <= '0;
            st       <= ST_DRAW;
          end else if (last_idx) begin
            st <= ST_DRAIN;
          end else begin
            idx <= idx + 1'b1;
            st  <= ST_FETCH;
          end
        end
        ST_DRAW: begin
          col <= col + 1'b1;
          if (col == col_last) begin
            if (last_idx) st <= ST_DRAIN;
            else begin
              idx <= idx + 1'b1;
              st  <= ST_FETCH;
            end
          end
        end
        ST_DRAIN: begin
          if (!pend) begin
            st   <= ST_DONE;
            done <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  AST_IDX_ORDER: assert property (@(posedge clk) disable iff (rst)
    (!line_start && st != ST_IDLE) |=> (idx >= $past(idx))); // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> !tex_req); // R9
  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (rst)
    line_start |=> !done); // R9
  AST_ROW_STABLE: assert property (@(posedge clk) disable iff (rst)
    (tex_req && $past(tex_req)) |-> (tex_addr[TEX_AW-1:COORD_W] == $past(tex_addr[TEX_AW-1:COORD_W]))); // R5
  AST_COL_STEP: assert property (@(posedge clk) disable iff (rst)
    (tex_req && $past(tex_req)) |-> (tex_addr[COORD_W-1:0] == $past(tex_addr[COORD_W-1:0]) + 8'd1)); // R5

endmodule

// File: rtl/spr_line_renderer.sv
module spr_line_renderer
  import spr_render_pkg::*;
#(
  parameter int ENTRIES     = 64,
  parameter int ENTRY_BYTES = 8,
  parameter int BASE_W      = 16,
  parameter int TEX_LAT     = 2,
  localparam int IDX_W      = $clog2(ENTRIES),
  localparam int CPU_AW     = IDX_W + $clog2(ENTRY_BYTES),
  localparam int TEX_AW     = BASE_W + COORD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_we,
  input  logic [CPU_AW-1:0]  cpu_addr,
  input  logic [7:0]         cpu_wdata,
  input  logic [BASE_W-1:0]  tex_base,
  input  logic               line_start,
  input  logic [COORD_W-1:0] line_num,
  output logic               tex_req,
  output logic [TEX_AW-1:0]  tex_addr,
  input  logic [7:0]         tex_rdata,
  input  logic [COORD_W-1:0] lb_raddr,
  output logic [7:0]         lb_rdata,
  output logic               done
);

  logic [IDX_W-1:0]   ridx;
  spr_entry_t         rentry;
  logic               lb_we;
  logic [COORD_W-1:0] lb_waddr;
  logic [7:0]         lb_wdata;

  spr_attr_ram #(
    .ENTRIES    (ENTRIES),
    .ENTRY_BYTES(ENTRY_BYTES)
  ) u_attr (
    .clk   (clk),
    .we    (cpu_we),
    .waddr (cpu_addr),
    .wdata (cpu_wdata),
    .ridx  (ridx),
    .rentry(rentry)
  );

  spr_line_seq #(
    .ENTRIES(ENTRIES),
    .BASE_W (BASE_W),
    .TEX_LAT(TEX_LAT)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .line_start(line_start),
    .line_num  (line_num),
    .tex_base  (tex_base),
    .ridx      (ridx),
    .rentry    (rentry),
    .tex_req   (tex_req),
    .tex_addr  (tex_addr),
    .tex_rdata (tex_rdata),
    .lb_we     (lb_we),
    .lb_waddr  (lb_waddr),
    .lb_wdata  (lb_wdata),
    .done      (done)
  );

  spr_line_buf #(
    .DEPTH(1 << COORD_W),
    .DW   (8)
  ) u_lbuf (
    .clk  (clk),
    .we   (lb_we),
    .waddr(lb_waddr),
    .wdata(lb_wdata),
    .raddr(lb_raddr),
    .rdata(lb_rdata)
  );

endmodule

// File: tb/spr_line_renderer_test.sv
`timescale 1ns/1ps
module spr_line_renderer_test;

  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst;
  logic        cpu_we;
  logic [8:0]  cpu_addr;
  logic [7:0]  cpu_wdata;
  logic [15:0] tex_base;
  logic        line_start;
  logic [7:0]  line_num;
  logic        tex_req;
  logic [23:0] tex_addr;
  logic [7:0]  tex_rdata;
  logic [7:0]  lb_raddr;
  logic [7:0]  lb_rdata;
  logic        done;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  spr_line_renderer #(.TEX_LAT(LAT)) uut (
    .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .tex_base(tex_base), .line_start(line_start),
    .line_num(line_num), .tex_req(tex_req), .tex_addr(tex_addr),
    .tex_rdata(tex_rdata), .lb_raddr(lb_raddr), .lb_rdata(lb_rdata),
    .done(done)
  );

  // texture model: value from address, zero where the low nibble is zero
  function automatic logic [7:0] texel(input logic [23:0] a);
    logic [7:0] v;
    v = a[7:0] + 8'(a[15:8] * 3) + 8'(a[23:16] * 7);
    if (a[3:0] == 4'd0) return 8'd0;
    if (v == 8'd0) return 8'd1;
    return v;
  endfunction

  logic        breq  [LAT];
  logic [23:0] baddr [LAT];
  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < LAT; k++) begin breq[k] <= 1'b0; baddr[k] <= '0; end
    end else begin
      breq[0]  <= tex_req;
      baddr[0] <= tex_addr;
      for (int k = 1; k < LAT; k++) begin breq[k] <= breq[k-1]; baddr[k] <= baddr[k-1]; end
    end
  end
  assign tex_rdata = breq[LAT-1] ? texel(baddr[LAT-1]) : 8'h00;

  logic [7:0] bm  [512];
  logic [7:0] exp_line [256];

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic wr_byte(input int a, input logic [7:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = 9'(a); cpu_wdata = d;
    bm[a] = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic set_sprite(input int i, input logic [7:0] at, input logic [7:0] y,
                            input logic [7:0] x, input logic [7:0] tx, input logic [7:0] ty);
    wr_byte(i*8+0, at); wr_byte(i*8+1, y); wr_byte(i*8+2, x);
    wr_byte(i*8+4, tx); wr_byte(i*8+5, ty);
  endtask

  task automatic clear_table();
    for (int i = 0; i < 64; i++) wr_byte(i*8, 8'h00);
  endtask

  task automatic model_line(input logic [7:0] ln);
    for (int p = 0; p < 256; p++) exp_line[p] = 8'h00;
    for (int i = 0; i < 64; i++) begin
      logic [7:0] at, y, x, tx, ty, dy, rw, px;
      int w, h;
      logic [23:0] a;
      at = bm[i*8]; y = bm[i*8+1]; x = bm[i*8+2]; tx = bm[i*8+4]; ty = bm[i*8+5];
      if (at[7]) begin
        w = at[0] ? 16 : 8;
        h = at[1] ? 16 : 8;
        dy = ln - y;
        if (int'(dy) < h) begin
          rw = at[3] ? 8'(h - 1 - int'(dy)) : dy;
          for (int c = 0; c < w; c++) begin
            a = {tex_base, 8'h00} + {8'h00, 8'(ty + rw), 8'h00} + {16'h0, 8'(tx + 8'(c))};
            px = at[2] ? 8'(x + 8'(w - 1 - c)) : 8'(x + 8'(c));
            if (texel(a) != 8'd0) exp_line[px] = texel(a);
          end
        end
      end
    end
  endtask

  // renders one line and compares all 256 pixels
  task automatic run_line(input logic [7:0] ln, input string tag);
    int guard;
    model_line(ln);
    @(negedge clk);
    line_start = 1'b1; line_num = ln;
    @(negedge clk);
    line_start = 1'b0;
    chk("R9 done low after line start", int'(done), 0);
    guard = 0;
    while (!done && guard < 5000) begin @(negedge clk); guard++; end
    chk("R9 done raised", int'(done), 1);
    chk("R9 no request while done", int'(tex_req), 0);
    for (int p = 0; p < 256; p++) begin
      lb_raddr = 8'(p);
      @(negedge clk);
      chk(tag, int'(lb_rdata), int'(exp_line[p]));
    end
  endtask

  task automatic t_reset();
    chk("R9 reset done", int'(done), 0);
    chk("R9 reset request", int'(tex_req), 0);
  endtask

  task automatic t_basic();  // R5 R10
    clear_table();
    set_sprite(0, 8'h80, 8'd10, 8'd20, 8'd5, 8'd7);
    run_line(8'd12, "R5 R10 basic sprite");
    run_line(8'd18, "R3 line below 8-tall sprite");
  endtask

  task automatic t_size();  // R3
    clear_table();
    set_sprite(0, 8'h83, 8'd40, 8'd60, 8'd33, 8'd2);
    set_sprite(1, 8'h81, 8'd40, 8'd100, 8'd9, 8'd50);
    run_line(8'd52, "R3 tall and wide");
  endtask

  task automatic t_flip();  // R4
    clear_table();
    set_sprite(2, 8'h84, 8'd5, 8'd10, 8'd3, 8'd0);
    set_sprite(3, 8'h88, 8'd5, 8'd40, 8'd3, 8'd0);
    set_sprite(4, 8'h8F, 8'd1, 8'd80, 8'd17, 8'd90);
    run_line(8'd7, "R4 mirror");
  endtask

  task automatic t_disabled();  // R2
    clear_table();
    set_sprite(0, 8'h0F, 8'd30, 8'd30, 8'd1, 8'd1);
    set_sprite(1, 8'h80, 8'd30, 8'd70, 8'd1, 8'd1);
    run_line(8'd31, "R2 disabled entry");
  endtask

  task automatic t_wrap();  // R7 R5
    clear_table();
    set_sprite(7, 8'h83, 8'd250, 8'd250, 8'd250, 8'd252);
    run_line(8'd3, "R7 screen and texture wrap");
  endtask

  task automatic t_prio();  // R8 R6
    clear_table();
    set_sprite(5, 8'h81, 8'd100, 8'd30, 8'd1, 8'd20);
    set_sprite(6, 8'h81, 8'd100, 8'd34, 8'd65, 8'd99);
    set_sprite(63, 8'h80, 8'd100, 8'd36, 8'd200, 8'd3);
    run_line(8'd104, "R8 R6 overlap order and holes");
  endtask

  task automatic t_ignored();  // R1
    clear_table();
    set_sprite(0, 8'h80, 8'd10, 8'd20, 8'd5, 8'd7);
    wr_byte(3, 8'hFF); wr_byte(6, 8'hFF); wr_byte(7, 8'hFF);
    wr_byte(8*9+3, 8'hFF);
    run_line(8'd12, "R1 unused entry bytes");
  endtask

  task automatic t_base();  // R5
    clear_table();
    tex_base = 16'hF234;
    set_sprite(9, 8'h83, 8'd0, 8'd128, 8'd121, 8'd200);
    run_line(8'd14, "R5 page base");
    tex_base = 16'h0000;
  endtask

  task automatic t_clear();  // R9
    clear_table();
    set_sprite(0, 8'h83, 8'd0, 8'd0, 8'd1, 8'd1);
    run_line(8'd2, "R9 drawn line");
    wr_byte(0, 8'h00);
    run_line(8'd2, "R9 cleared line");
  endtask

  initial begin
    int wd;
    wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    tex_base = '0; line_start = 1'b0; line_num = '0; lb_raddr = '0;
    for (int i = 0; i < 512; i++) bm[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_size();
    t_flip();
    t_disabled();
    t_wrap();
    t_prio();
    t_ignored();
    t_base();
    t_clear();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule